// File: doc/BRIEF.md
# Serial Line Break Detector

This block sits behind the bit sampler of an asynchronous serial receiver. It takes one line sample per bit time, marked by a bit-valid strobe, and frames the samples into characters. The frame format comes from the configuration inputs: data length, parity enable and one or two stop bits. Each finished character goes out on a valid/ready stream with parity-error and framing-error flags. The character slot holds one entry. A character stays on the output until the consumer takes it. If a frame completes while the slot is still full and is not being accepted in that cycle, the new frame is discarded.

A frame in which every sample is 0 is a line break. This covers the start bit, the data bits, the parity bit when enabled, and every stop bit. A break frame is never put on the stream. The block then raises a break-active level and, if enabled, a one-cycle break interrupt. While the break lasts, further 0 samples are swallowed. No characters are framed and no further break interrupts are raised. The first 1 sample ends the break. It drops the level and, if enabled, raises a one-cycle break-end interrupt. After that the receiver hunts for a new start bit.

Top module: `brk_det`

## Requirements
- R1: A frame is a 0 start bit, then `cfg_len`+1 data bits sent least significant bit first, then an even parity bit when `cfg_par_en` is 1, then one stop bit (or two when `cfg_stop2` is 1). The character appears on `out_data` right-justified, with the unused upper bits at 0.
- R2: `out_perr` is 1 when parity is enabled and the data bits together with the parity bit hold an odd number of ones. Otherwise it is 0.
- R3: A frame that has any stop bit at 0 but is not all zero is delivered with `out_ferr` = 1.
- R4: A frame with all data bits 0 (and parity 0 if enabled) is delivered as a normal character 0x00 when its stop bits are all 1.
- R5: A frame whose every sample is 0 is a break. It sets `brk_active` and is not delivered on the stream.
- R6: `brk_irq` pulses for exactly one cycle when a break is recognised, and only when `brk_irq_en` is 1.
- R7: While `brk_active` is 1, 0 samples are ignored. No character is delivered and no further `brk_irq` occurs.
- R8: The first 1 sample during a break clears `brk_active`. It also pulses `brkt_irq` for one cycle, but only when `brkt_irq_en` is 1.
- R9: While `out_vld` is 1 and `out_rdy` is 0, the output character and its flags stay stable. A frame that completes in that state is discarded.
- R10: When no frame is in progress and no break is active, 1 samples are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One line sample is present this cycle |
| bit_val | input | 1 | Sampled line level |
| cfg_len | input | 3 | Data bits minus one (legal 4..7) |
| cfg_par_en | input | 1 | Even parity bit present |
| cfg_stop2 | input | 1 | Two stop bits instead of one |
| brk_irq_en | input | 1 | Enables the break interrupt |
| brkt_irq_en | input | 1 | Enables the break-end interrupt |
| out_vld | output | 1 | Character slot holds a character |
| out_rdy | input | 1 | Consumer accepts the character |
| out_data | output | 8 | Received character, right-justified |
| out_perr | output | 1 | Parity error flag of the character |
| out_ferr | output | 1 | Framing error flag of the character |
| brk_active | output | 1 | Break in progress |
| brk_irq | output | 1 | Break recognised strobe |
| brkt_irq | output | 1 | Break ended strobe |

## Verification
The assertions check several rules on every cycle. Break-active can only rise after a 0 sample and only fall after a 1 sample. Nothing is framed while a break is active. Both interrupts are single-cycle and follow their enables. A stalled output character holds steady. Other behaviour only shows up in the bench scenarios: frame assembly across lengths, parity and stop-bit counts, the error flags, the all-zero character with a good stop bit, a near-break with one bad stop bit, suppression of the break frame, and the dropping of a frame while the slot is stalled.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_st_e;
endpackage

// File: rtl/brk_framer.sv
module brk_framer #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_val,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_stop2,
  output logic          frm_vld,
  output logic [DW-1:0] frm_data,
  output logic          frm_perr,
  output logic          frm_ferr,
  output logic          brk_set,
  output logic          brk_clr,
  output logic          brk_active
);
  import brk_pkg::*;

  rx_st_e        st;
  logic [LW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          par_acc;
  logic          seen_one;
  logic          stop_bad;
  logic          stop_idx;

  assign brk_active = (st == ST_BRK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      seen_one <= 1'b0;
      stop_bad <= 1'b0;
      stop_idx <= 1'b0;
      frm_vld  <= 1'b0;
      frm_data <= '0;
      frm_perr <= 1'b0;
      frm_ferr <= 1'b0;
      brk_set  <= 1'b0;
      brk_clr  <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      brk_set <= 1'b0;
      brk_clr <= 1'b0;
      if (bit_vld) begin
        case (st)
          ST_IDLE: begin
            if (!bit_val) begin
              st       <= ST_DATA;
              cnt      <= '0;
              shreg    <= '0;
              par_acc  <= 1'b0;
              seen_one <= 1'b0;
              stop_bad <= 1'b0;
              stop_idx <= 1'b0;
            end
          end
          ST_DATA: begin
            shreg[cnt] <= bit_val;
            par_acc    <= par_acc ^ bit_val;
            seen_one   <= seen_one | bit_val;
            if (cnt == cfg_len) st <= cfg_par_en ? ST_PAR : ST_STOP;
            else                cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            par_acc  <= par_acc ^ bit_val;
            seen_one <= seen_one | bit_val;
            st       <= ST_STOP;
          end
          ST_STOP: begin
            if (cfg_stop2 && !stop_idx) begin
              stop_idx <= 1'b1;
              stop_bad <= stop_bad | !bit_val;
              seen_one <= seen_one | bit_val;
            end else if (!seen_one && !bit_val) begin
              st      <= ST_BRK;
              brk_set <= 1'b1;
            end else begin
              st       <= ST_IDLE;
              frm_vld  <= 1'b1;
              frm_data <= shreg;
              frm_perr <= cfg_par_en & par_acc;
              frm_ferr <= stop_bad | !bit_val;
            end
          end
          ST_BRK: begin
            if (bit_val) begin
              st      <= ST_IDLE;
              brk_clr <= 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  p_brk_after_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_active) |-> $past(bit_vld && !bit_val));

  p_brk_end_on_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active) |-> $past(bit_vld && bit_val));

  p_quiet_in_brk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |=> (!frm_vld && !brk_set));
endmodule

// File: rtl/brk_char_hold.sv
module brk_char_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_vld,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_perr,
  input  logic          frm_ferr,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [DW-1:0] out_data,
  output logic          out_perr,
  output logic          out_ferr
);
  logic take;
  assign take = frm_vld && (!out_vld || out_rdy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_perr <= 1'b0;
      out_ferr <= 1'b0;
    end else if (take) begin
      out_vld  <= 1'b1;
      out_data <= frm_data;
      out_perr <= frm_perr;
      out_ferr <= frm_ferr;
    end else if (out_rdy) begin
      out_vld <= 1'b0;
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_perr) && $stable(out_ferr)));
endmodule

// File: rtl/brk_irq_gate.sv
module brk_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_set,
  input  logic brk_clr,
  input  logic brk_irq_en,
  input  logic brkt_irq_en,
  output logic brk_irq,
  output logic brkt_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_irq  <= 1'b0;
      brkt_irq <= 1'b0;
    end else begin
      brk_irq  <= brk_set & brk_irq_en;
      brkt_irq <= brk_clr & brkt_irq_en;
    end
  end

  p_brk_irq_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> $past(brk_irq_en));

  p_brk_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> !brk_irq);

  p_brkt_irq_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brkt_irq |-> $past(brkt_irq_en));

  p_brkt_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brkt_irq |=> !brkt_irq);
endmodule

// File: rtl/brk_det.sv
module brk_det #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_val,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_stop2,
  input  logic          brk_irq_en,
  input  logic          brkt_irq_en,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [DW-1:0] out_data,
  output logic          out_perr,
  output logic          out_ferr,
  output logic          brk_active,
  output logic          brk_irq,
  output logic          brkt_irq
);
  logic          frm_vld;
  logic [DW-1:0] frm_data;
  logic          frm_perr;
  logic          frm_ferr;
  logic          brk_set;
  logic          brk_clr;

  brk_framer #(.DW(DW)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_perr(frm_perr),
    .frm_ferr(frm_ferr), .brk_set(brk_set), .brk_clr(brk_clr),
    .brk_active(brk_active)
  );

  brk_char_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_data(frm_data),
    .frm_perr(frm_perr), .frm_ferr(frm_ferr), .out_vld(out_vld),
    .out_rdy(out_rdy), .out_data(out_data), .out_perr(out_perr),
    .out_ferr(out_ferr)
  );

  brk_irq_gate u_irq (
    .clk(clk), .rst_n(rst_n), .brk_set(brk_set), .brk_clr(brk_clr),
    .brk_irq_en(brk_irq_en), .brkt_irq_en(brkt_irq_en),
    .brk_irq(brk_irq), .brkt_irq(brkt_irq)
  );
endmodule

// File: tb/brk_det_tb.sv
module brk_det_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_val = 1'b1;
  logic [2:0] cfg_len = 3'd7;
  logic       cfg_par_en = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       brk_irq_en = 1'b1;
  logic       brkt_irq_en = 1'b1;
  logic       out_vld;
  logic       out_rdy = 1'b1;
  logic [7:0] out_data;
  logic       out_perr;
  logic       out_ferr;
  logic       brk_active;
  logic       brk_irq;
  logic       brkt_irq;

  int n_tests = 0;
  int n_fail = 0;
  int brk_seen = 0;
  int brkt_seen = 0;
  logic [9:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_det u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
    .brk_irq_en(brk_irq_en), .brkt_irq_en(brkt_irq_en),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .brk_active(brk_active),
    .brk_irq(brk_irq), .brkt_irq(brkt_irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: handshakes and interrupt strobes
  logic prev_brk = 1'b0;
  logic prev_brkt = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld && out_rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R9 unexpected character", {out_ferr, out_perr, out_data}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({out_ferr, out_perr, out_data} == e, "R1-R4 character", {out_ferr, out_perr, out_data}, e);
        end
      end
      if (brk_irq) brk_seen++;
      if (brkt_irq) brkt_seen++;
      if (brk_irq && prev_brk) chk(1'b0, "R6 brk_irq longer than one cycle", 1, 0);
      if (brkt_irq && prev_brkt) chk(1'b0, "R8 brkt_irq longer than one cycle", 1, 0);
      prev_brk = brk_irq;
      prev_brkt = brkt_irq;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_val = b;
    @(negedge clk);
    bit_vld = 1'b0;
    bit_val = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [7:0] m;
    m = 8'hFF >> (3'd7 - cfg_len);
    send_bit(1'b0);
    for (int i = 0; i <= int'(cfg_len); i++) send_bit(d[i]);
    if (cfg_par_en) send_bit((^(d & m)) ^ bad_par);
    if (cfg_stop2) send_bit(1'b1);
    send_bit(!bad_stop);
  endtask

  task automatic expect_char(input logic [7:0] d, input logic perr, input logic ferr);
    logic [7:0] m;
    m = 8'hFF >> (3'd7 - cfg_len);
    exp_q.push_back({ferr, perr, d & m});
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_vld && !brk_active && !brk_irq && !brkt_irq, "reset state", {out_vld, brk_active, brk_irq, brkt_irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: 8 data bits, no parity, one stop
    expect_char(8'hA5, 0, 0); send_frame(8'hA5, 0, 0);
    // R1: 5 bits with parity, then 7 bits with two stops
    cfg_len = 3'd4; cfg_par_en = 1'b1;
    expect_char(8'h13, 0, 0); send_frame(8'h13, 0, 0);
    cfg_len = 3'd6; cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
    expect_char(8'h55, 0, 0); send_frame(8'h55, 0, 0);
    // R2: bad parity
    cfg_len = 3'd7; cfg_par_en = 1'b1; cfg_stop2 = 1'b0;
    expect_char(8'h3C, 1, 0); send_frame(8'h3C, 1, 0);
    // R3: bad stop bit
    cfg_par_en = 1'b0;
    expect_char(8'h81, 0, 1); send_frame(8'h81, 0, 1);
    // R4: zero character with valid stop
    cfg_par_en = 1'b1;
    expect_char(8'h00, 0, 0); send_frame(8'h00, 0, 0);
    chk(!brk_active, "R4 zero char with stop is not a break", brk_active, 0);
    // R3: near-break, only the last of two stops is 0
    cfg_stop2 = 1'b1;
    expect_char(8'h00, 0, 1); send_frame(8'h00, 0, 1);
    chk(!brk_active, "R3 near-break not a break", brk_active, 0);
    // R10: idle ones ignored
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    chk(exp_q.size() == 0 && !out_vld, "R10 idle ones ignored", out_vld, 0);

    // R5, R6: break with 8 bits, parity, two stops = 12 zeros
    send_zeros(12);
    chk(brk_active, "R5 break active", brk_active, 1);
    chk(brk_seen == 1, "R6 one break interrupt", brk_seen, 1);
    // R7: further zeros swallowed
    send_zeros(20);
    chk(brk_active && brk_seen == 1 && !out_vld, "R7 quiet during break", brk_seen, 1);
    // R8: first one ends the break
    send_bit(1'b1);
    chk(!brk_active, "R8 break cleared", brk_active, 0);
    chk(brkt_seen == 1, "R8 break-end interrupt", brkt_seen, 1);
    // recovery
    cfg_len = 3'd7; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    expect_char(8'h5A, 0, 0); send_frame(8'h5A, 0, 0);

    // R6, R8 disabled: 5 bits, one stop = 7 zeros
    brk_irq_en = 1'b0; brkt_irq_en = 1'b0; cfg_len = 3'd4;
    send_zeros(7);
    chk(brk_active && brk_seen == 1, "R6 disabled break irq", brk_seen, 1);
    send_bit(1'b1);
    chk(!brk_active && brkt_seen == 1, "R8 disabled break-end irq", brkt_seen, 1);
    brk_irq_en = 1'b1; brkt_irq_en = 1'b1;

    // R9: stall, second frame dropped
    cfg_len = 3'd7;
    out_rdy = 1'b0;
    expect_char(8'hC3, 0, 0); send_frame(8'hC3, 0, 0);
    send_frame(8'h3F, 0, 0);
    chk(out_vld && out_data == 8'hC3, "R9 held character", out_data, 8'hC3);
    out_rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_vld && exp_q.size() == 0, "R9 dropped frame never appears", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected characters delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule